// File: doc/BRIEF.md
# Pin Connectivity NAND Chain

This block gives a board-level connectivity test for a group of bidirectional bus pins without any dedicated test-select pin. Holding the chip reset active puts the block in test mode. In test mode every participating pin loses its output enable, so the tester alone drives the pins. The value each pin receives is folded into a chain of two-input NAND gates, and the last gate drives one result output.

A tester walks patterns across the pins and watches the single result output. A pin that is open or shorted then shows up as a result that does not toggle. When reset is released, the functional output enables pass straight through and the result output rests at 0.

The chain is purely combinational. The pin count, the polarity of the reset input and the end of the pin group the chain starts from are all parameters.

Top module: `pin_nand_tree`

## Requirements
- R1: Test mode is active exactly while `rst_in` is at its asserted level. The asserted level is 0 when `RST_ACTIVE_LOW` is 1, and 1 when `RST_ACTIVE_LOW` is 0.
- R2: In test mode every bit of `pin_oe` is 0, whatever the value of `func_oe`.
- R3: Outside test mode `pin_oe` equals `func_oe` bit for bit.
- R4: Outside test mode `tree_out` is 0, whatever the value of `pin_in`.
- R5: In test mode, chain position 0 carries the value of the first pin. Each later position k carries NOT(position k-1 AND the pin at position k). `tree_out` shows the last position. With every pin low, `tree_out` is 1 for two or more pins.
- R6: With `CHAIN_ORDER` = `CHAIN_LSB_FIRST`, chain position k reads `pin_in[k]`. With `CHAIN_MSB_FIRST`, position k reads `pin_in[NUM_PINS-1-k]`.
- R7: In test mode with every pin high, `tree_out` is 1 when `NUM_PINS` is odd and 0 when it is even.
- R8: In test mode with all other pins high, driving low the pin at chain position 0, or at any odd chain position, inverts `tree_out` compared with the all-high result. Driving low a pin at an even position other than 0 leaves `tree_out` unchanged.
- R9: `NUM_PINS` below 2 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_in | input | 1 | Chip reset; its asserted level selects test mode |
| func_oe | input | NUM_PINS | Output enables requested by the functional logic |
| pin_in | input | NUM_PINS | Values received on the bus pins |
| pin_oe | output | NUM_PINS | Final output enables to the pad cells |
| tree_out | output | 1 | Chain result in test mode, 0 otherwise |

## Verification
The embedded assertions check the enable gating on every evaluation, both forced-off and pass-through. They also check that the result output is idle outside test mode, and they check the chain's result for the all-high and all-low pin patterns. Only the bench's sweeps can show the full NAND recurrence and the mapping from chain position to pin index. It sweeps every pin pattern of a 16-pin LSB-first instance and of a 5-pin MSB-first instance with an active-high reset, and it walks a single low pin across each chain position.

// File: rtl/nand_tree_pkg.sv
package nand_tree_pkg;

   // Which end of the pin vector feeds chain position 0
   typedef enum logic {
      CHAIN_LSB_FIRST = 1'b0,
      CHAIN_MSB_FIRST = 1'b1
   } chain_order_e;

endpackage

// File: rtl/ntree_mode_detect.sv
module ntree_mode_detect #(
   parameter bit RST_ACTIVE_LOW = 1'b1
) (
   input  logic rst_in,
   output logic test_mode
);

   generate
      if (RST_ACTIVE_LOW) begin : g_low
         assign test_mode = ~rst_in;
      end else begin : g_high
         assign test_mode = rst_in;
      end
   endgenerate

endmodule

// File: rtl/ntree_oe_gate.sv
module ntree_oe_gate #(
   parameter int unsigned NUM_PINS = 16
) (
   input  logic                test_mode,
   input  logic [NUM_PINS-1:0] func_oe,
   output logic [NUM_PINS-1:0] pin_oe
);

   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
         assign pin_oe[i] = func_oe[i] & ~test_mode;
      end
   endgenerate

endmodule

// File: rtl/ntree_stage_chain.sv
module ntree_stage_chain
   import nand_tree_pkg::*;
#(
   parameter int unsigned  NUM_PINS    = 16,
   parameter chain_order_e CHAIN_ORDER = CHAIN_LSB_FIRST
) (
   input  logic [NUM_PINS-1:0] pin_in,
   output logic                chain_end
);

   localparam int unsigned LAST = NUM_PINS - 1;

   logic [NUM_PINS-1:0] ordered;
   logic [NUM_PINS-1:0] stage;

   generate
      for (genvar k = 0; k < NUM_PINS; k++) begin : g_order
         if (CHAIN_ORDER == CHAIN_MSB_FIRST) begin : g_msb
            assign ordered[k] = pin_in[LAST-k];
         end else begin : g_lsb
            assign ordered[k] = pin_in[k];
         end
      end

      assign stage[0] = ordered[0];
      for (genvar k = 1; k < NUM_PINS; k++) begin : g_stage
         assign stage[k] = ~(stage[k-1] & ordered[k]);
      end
   endgenerate

   assign chain_end = stage[LAST];

endmodule

// File: rtl/pin_nand_tree.sv
module pin_nand_tree
   import nand_tree_pkg::*;
#(
   parameter int unsigned  NUM_PINS       = 16,
   parameter bit           RST_ACTIVE_LOW = 1'b1,
   parameter chain_order_e CHAIN_ORDER    = CHAIN_LSB_FIRST
) (
   input  logic                rst_in,
   input  logic [NUM_PINS-1:0] func_oe,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic                tree_out
);

   localparam logic ALL_HIGH_RESULT = NUM_PINS[0];

   // R9: elaboration-time parameter check
   generate
      if (NUM_PINS < 2) begin : g_bad_count
         $error("pin_nand_tree: NUM_PINS must be at least 2");
      end
   endgenerate

   logic test_mode;
   logic chain_end;

   ntree_mode_detect #(
      .RST_ACTIVE_LOW (RST_ACTIVE_LOW)
   ) u_mode (
      .rst_in    (rst_in),
      .test_mode (test_mode)
   );

   ntree_oe_gate #(
      .NUM_PINS (NUM_PINS)
   ) u_oe (
      .test_mode (test_mode),
      .func_oe   (func_oe),
      .pin_oe    (pin_oe)
   );

   ntree_stage_chain #(
      .NUM_PINS    (NUM_PINS),
      .CHAIN_ORDER (CHAIN_ORDER)
   ) u_chain (
      .pin_in    (pin_in),
      .chain_end (chain_end)
   );

   assign tree_out = test_mode & chain_end;

   always_comb begin
      if (test_mode) begin
         AST_OE_FORCED_OFF: assert (pin_oe == '0);                          // R2
      end
      if (!test_mode) begin
         AST_OE_PASSTHRU: assert (pin_oe == func_oe);                       // R3
         AST_RESULT_IDLE: assert (tree_out == 1'b0);                        // R4
      end
      if (test_mode && (&pin_in)) begin
         AST_ALL_HIGH_RESULT: assert (tree_out == ALL_HIGH_RESULT);         // R7
      end
      if (test_mode && (pin_in == '0)) begin
         AST_ALL_LOW_RESULT: assert (tree_out == 1'b1);                     // R5
      end
   end

endmodule

// File: tb/test_pin_nand_tree.sv
`timescale 1ns/100ps
module test_pin_nand_tree;
   import nand_tree_pkg::*;

   localparam int NA = 16;
   localparam int NB = 5;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // Instance A: 16 pins, active-low reset, LSB first
   logic          rst_a;
   logic [NA-1:0] foe_a, pin_a, oe_a;
   logic          out_a;

   pin_nand_tree #(
      .NUM_PINS (NA), .RST_ACTIVE_LOW (1'b1), .CHAIN_ORDER (CHAIN_LSB_FIRST)
   ) i_pin_nand_tree (
      .rst_in (rst_a), .func_oe (foe_a), .pin_in (pin_a),
      .pin_oe (oe_a), .tree_out (out_a)
   );

   // Instance B: 5 pins, active-high reset, MSB first
   logic          rst_b;
   logic [NB-1:0] foe_b, pin_b, oe_b;
   logic          out_b;

   pin_nand_tree #(
      .NUM_PINS (NB), .RST_ACTIVE_LOW (1'b0), .CHAIN_ORDER (CHAIN_MSB_FIRST)
   ) i_pin_nand_tree_rev (
      .rst_in (rst_b), .func_oe (foe_b), .pin_in (pin_b),
      .pin_oe (oe_b), .tree_out (out_b)
   );

   // Reference from the recurrence of R5 and the ordering of R6
   function automatic logic model(input logic [15:0] p, input int n, input bit msb);
      logic s;
      s = p[msb ? n-1 : 0];
      for (int k = 1; k < n; k++) s = ~(s & p[msb ? n-1-k : k]);
      return s;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      rst_a = 1'b1; foe_a = '1; pin_a = '0;
      rst_b = 1'b0; foe_b = '1; pin_b = '0;
      @(negedge clk);

      // R1/R3/R4 reset released: enables pass through, result idle
      chk("R3 idle oe A", oe_a, foe_a);
      chk("R4 idle out A", out_a, 0);
      chk("R3 idle oe B", oe_b, foe_b);
      for (int v = 0; v < 64; v++) begin
         foe_a = NA'(v * 1237 + 11); pin_a = NA'(v * 4099 + 3);
         foe_b = NB'(v * 7 + 1);     pin_b = NB'(v * 3);
         step();
         chk("R3 passthru A", oe_a, foe_a);
         chk("R4 out idle A", out_a, 0);
         chk("R3 passthru B", oe_b, foe_b);
         chk("R4 out idle B", out_b, 0);
      end

      // R1 enter test mode: active-low for A, active-high for B
      rst_a = 1'b0; rst_b = 1'b1; foe_a = '1; foe_b = '1;
      step();
      chk("R1 R2 oe off A", oe_a, 0);
      chk("R1 R2 oe off B", oe_b, 0);

      // R7 all high
      pin_a = '1; pin_b = '1; step();
      chk("R7 all high A", out_a, 0);
      chk("R7 all high B", out_b, 1);

      // R5 all low
      pin_a = '0; pin_b = '0; step();
      chk("R5 all low A", out_a, 1);
      chk("R5 all low B", out_b, 1);

      // R8 walking single low per chain position
      for (int k = 0; k < NA; k++) begin
         pin_a = '1; pin_a[k] = 1'b0; step();
         chk("R8 walk A", out_a, ((k == 0) || (k % 2 == 1)) ? 1 : 0);
      end
      for (int k = 0; k < NB; k++) begin
         pin_b = '1; pin_b[NB-1-k] = 1'b0; step();
         chk("R8 R6 walk B", out_b, ((k == 0) || (k % 2 == 1)) ? 0 : 1);
      end

      // R5/R6/R2 exhaustive sweeps in test mode
      for (int v = 0; v < (1 << NA); v++) begin
         pin_a = NA'(v); foe_a = ~NA'(v);
         pin_b = NB'(v); foe_b = NB'(v);
         step();
         chk("R5 R6 sweep A", out_a, model(16'(v), NA, 1'b0));
         chk("R2 sweep A", oe_a, 0);
         if (v < (1 << NB)) begin
            chk("R5 R6 sweep B", out_b, model(16'(v & 31), NB, 1'b1));
            chk("R2 sweep B", oe_b, 0);
         end
      end

      // R1 leave test mode again
      rst_a = 1'b1; rst_b = 1'b0; foe_a = 16'hA5C3; foe_b = 5'h15; pin_a = '0; pin_b = '0;
      step();
      chk("R1 R3 exit A", oe_a, 16'hA5C3);
      chk("R1 R4 exit A", out_a, 0);
      chk("R1 R3 exit B", oe_b, 5'h15);
      chk("R1 R4 exit B", out_b, 0);

      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule